// File: doc/BRIEF.md
# Per-Instruction Stride Prefetcher

The block watches a stream of observed loads, each carrying the instruction address of the load and the data address it touched. It tracks a separate address pattern for every load instruction in a small direct-mapped table. When one instruction keeps stepping through memory by the same non-zero distance, the block predicts the next address and offers it as a prefetch request.

Each table entry holds a partial tag, the last data address, the last observed stride and a saturating confidence count. Strides may go forward or backward. The block only makes a prediction when the stride magnitude is within a cap and the predicted line stays inside the page of the current load. The block also drops a prediction that repeats the line it generated just before.

Prefetch requests leave through a single valid/ready output slot. The load side never waits. A newer prediction overwrites one that has not yet been accepted.

Top module: `stride_pf`

## Requirements
- R1: After reset `pf_valid` is low and every table entry is empty, so the first loads of any instruction produce no request.
- R2: Each load instruction is tracked on its own entry, selected by `ld_pc[3:0]` with `ld_pc[11:4]` as tag. Interleaved loads of different instructions train independently.
- R3: The stride is the current address minus the stored last address. When it equals the stored stride, the 2-bit confidence rises and saturates at 3; any other stride clears it to 0 and becomes the stored stride. A request is considered only when the stride matches and the confidence after the update is at least 2. For a constant stride this is the fourth load, and it takes three more matching loads after a break.
- R4: A request carries `ld_addr + stride` with bits [5:0] cleared, a 64-byte line. It appears on `pf_valid`/`pf_addr` in the cycle after the clock edge that captured the load.
- R5: Negative (descending) strides are predicted like positive ones.
- R6: A stride whose magnitude is at most 2048 bytes can trigger a request; a larger magnitude never does.
- R7: A zero stride never triggers a request.
- R8: No request is made when the predicted address lies in a different 4 KB page (bits [31:12] differ) from the load address.
- R9: A prediction whose line equals the line of the last request generated since reset is dropped, even if that request was already accepted.
- R10: A load whose tag differs from the tag in its entry replaces the entry with its own tag and address, a zero stride and zero confidence.
- R11: A pending request stays valid while `pf_ready` is low. A newer request replaces it. Without a new request, `pf_valid` falls in the cycle after a handshake (`pf_valid && pf_ready` at a clock edge).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | An observed load is present this cycle |
| ld_pc | input | PC_W (12) | Instruction address of the load |
| ld_addr | input | ADDR_W (32) | Data address of the load |
| pf_ready | input | 1 | Consumer accepts the prefetch request |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_addr | output | ADDR_W (32) | Line-aligned prefetch address |

## Verification
Every result of this block is due exactly one rising edge after the load that causes it. The table update and the output slot are both written on the edge that captures the load. A handshake likewise clears `pf_valid` one edge after `pf_ready` is seen. The bench drives each load on a falling edge, advances its behavioural model by that one load, and compares `pf_valid` and `pf_addr` on the next falling edge. The scenarios use hand-computed addresses, such as the fourth load of a constant stride, so that the expected prediction is known in advance.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;

  // Outcome of evaluating one observed load, exposed for checking
  typedef enum logic [2:0] {
    PFR_IDLE,   // no load this cycle
    PFR_TRAIN,  // stride not yet trusted
    PFR_ZERO,   // trusted but zero stride
    PFR_FAR,    // stride beyond magnitude cap
    PFR_PAGE,   // target leaves the page
    PFR_DUP,    // target line equals last generated line
    PFR_FIRE    // request generated
  } pf_reason_e;

  function automatic int unsigned bits_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/spf_table.sv
module spf_table #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int TAG_W   = 8,
  parameter int ADDR_W  = 32,
  parameter int CONF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [ADDR_W-1:0] rd_last,
  output logic [ADDR_W-1:0] rd_stride,
  output logic [CONF_W-1:0] rd_conf,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_last,
  input  logic [ADDR_W-1:0] wr_stride,
  input  logic [CONF_W-1:0] wr_conf
);

  logic              ent_v      [ENTRIES];
  logic [TAG_W-1:0]  ent_tag    [ENTRIES];
  logic [ADDR_W-1:0] ent_last   [ENTRIES];
  logic [ADDR_W-1:0] ent_stride [ENTRIES];
  logic [CONF_W-1:0] ent_conf   [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic              v_q;
    logic [TAG_W-1:0]  tag_q;
    logic [ADDR_W-1:0] last_q;
    logic [ADDR_W-1:0] stride_q;
    logic [CONF_W-1:0] conf_q;
    logic              sel;

    assign sel = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q      <= 1'b0;
        tag_q    <= '0;
        last_q   <= '0;
        stride_q <= '0;
        conf_q   <= '0;
      end else if (sel) begin
        v_q      <= 1'b1;
        tag_q    <= wr_tag;
        last_q   <= wr_last;
        stride_q <= wr_stride;
        conf_q   <= wr_conf;
      end
    end

    assign ent_v[e]      = v_q;
    assign ent_tag[e]    = tag_q;
    assign ent_last[e]   = last_q;
    assign ent_stride[e] = stride_q;
    assign ent_conf[e]   = conf_q;
  end

  assign rd_valid  = ent_v[rd_idx];
  assign rd_tag    = ent_tag[rd_idx];
  assign rd_last   = ent_last[rd_idx];
  assign rd_stride = ent_stride[rd_idx];
  assign rd_conf   = ent_conf[rd_idx];

endmodule

// File: rtl/spf_predict.sv
module spf_predict
  import stride_pf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PC_W       = 12,
  parameter int IDX_W      = 4,
  parameter int TAG_W      = 8,
  parameter int CONF_W     = 2,
  parameter int CONF_FIRE  = 2,
  parameter int LINE_LSB   = 6,
  parameter int PAGE_LSB   = 12,
  parameter int MAX_STRIDE = 2048
) (
  input  logic              ld_valid,
  input  logic [PC_W-1:0]   ld_pc,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_valid,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic [ADDR_W-1:0] rd_last,
  input  logic [ADDR_W-1:0] rd_stride,
  input  logic [CONF_W-1:0] rd_conf,
  input  logic              last_valid,
  input  logic [ADDR_W-1:0] last_line,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [ADDR_W-1:0] wr_last,
  output logic [ADDR_W-1:0] wr_stride,
  output logic [CONF_W-1:0] wr_conf,
  output pf_reason_e        cand_reason,
  output logic              cand_fire,
  output logic [ADDR_W-1:0] cand_addr,
  output logic [ADDR_W-1:0] cand_line,
  output logic [ADDR_W-1:0] cand_stride
);

  localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << LINE_LSB) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] PAGE_MASK = ~((ADDR_W'(1) << PAGE_LSB) - ADDR_W'(1));
  localparam logic [CONF_W-1:0] CONF_MAX  = '1;

  function automatic logic [CONF_W-1:0] conf_bump(input logic [CONF_W-1:0] c);
    return (c == CONF_MAX) ? c : c + CONF_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] stride_mag(input logic [ADDR_W-1:0] s);
    return s[ADDR_W-1] ? (~s + ADDR_W'(1)) : s;
  endfunction

  function automatic logic stride_far(input logic [ADDR_W-1:0] s);
    return stride_mag(s) > ADDR_W'(MAX_STRIDE);
  endfunction

  function automatic logic [ADDR_W-1:0] line_base(input logic [ADDR_W-1:0] a);
    return a & LINE_MASK;
  endfunction

  function automatic logic crosses_page(input logic [ADDR_W-1:0] a,
                                        input logic [ADDR_W-1:0] b);
    return ((a ^ b) & PAGE_MASK) != '0;
  endfunction

  logic [TAG_W-1:0]  ld_tag;
  logic              hit;
  logic [ADDR_W-1:0] diff;
  logic              same;
  logic [CONF_W-1:0] conf_next;
  logic              trusted;
  logic              dup;

  assign rd_idx    = ld_pc[IDX_W-1:0];
  assign ld_tag    = ld_pc[PC_W-1:IDX_W];
  assign hit       = rd_valid && (rd_tag == ld_tag);
  assign diff      = ld_addr - rd_last;
  assign same      = hit && (diff == rd_stride);
  assign conf_next = same ? conf_bump(rd_conf) : '0;
  assign trusted   = same && (conf_next >= CONF_W'(CONF_FIRE));

  assign cand_stride = diff;
  assign cand_addr   = ld_addr + diff;
  assign cand_line   = line_base(cand_addr);
  assign dup         = last_valid && (cand_line == last_line);

  always_comb begin
    if (!ld_valid)                          cand_reason = PFR_IDLE;
    else if (!trusted)                      cand_reason = PFR_TRAIN;
    else if (diff == '0)                    cand_reason = PFR_ZERO;
    else if (stride_far(diff))              cand_reason = PFR_FAR;
    else if (crosses_page(cand_addr, ld_addr)) cand_reason = PFR_PAGE;
    else if (dup)                           cand_reason = PFR_DUP;
    else                                    cand_reason = PFR_FIRE;
  end

  assign cand_fire = (cand_reason == PFR_FIRE);

  // Table update: a hit refreshes history, a miss claims the entry afresh
  assign wr_en     = ld_valid;
  assign wr_idx    = rd_idx;
  assign wr_tag    = ld_tag;
  assign wr_last   = ld_addr;
  assign wr_stride = hit ? diff : '0;
  assign wr_conf   = hit ? conf_next : '0;

endmodule

// File: rtl/spf_issue.sv
module spf_issue #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand_fire,
  input  logic [ADDR_W-1:0] cand_line,
  input  logic              pf_ready,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr,
  output logic              last_valid,
  output logic [ADDR_W-1:0] last_line
);

  logic              slot_v;
  logic [ADDR_W-1:0] slot_line;
  logic              seen_q;

  // The slot's address doubles as the last generated line for dedup
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v    <= 1'b0;
      slot_line <= '0;
      seen_q    <= 1'b0;
    end else if (cand_fire) begin
      slot_v    <= 1'b1;
      slot_line <= cand_line;
      seen_q    <= 1'b1;
    end else if (slot_v && pf_ready) begin
      slot_v    <= 1'b0;
    end
  end

  assign pf_valid   = slot_v;
  assign pf_addr    = slot_line;
  assign last_valid = seen_q;
  assign last_line  = slot_line;

endmodule

// File: rtl/stride_pf.sv
module stride_pf
  import stride_pf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PC_W       = 12,
  parameter int ENTRIES    = 16,
  parameter int CONF_W     = 2,
  parameter int CONF_FIRE  = 2,
  parameter int LINE_BYTES = 64,
  parameter int PAGE_BYTES = 4096,
  parameter int MAX_STRIDE = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [PC_W-1:0]   ld_pc,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              pf_ready,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);

  localparam int IDX_W    = bits_for(ENTRIES);
  localparam int TAG_W    = PC_W - IDX_W;
  localparam int LINE_LSB = bits_for(LINE_BYTES);
  localparam int PAGE_LSB = bits_for(PAGE_BYTES);

  logic [IDX_W-1:0]  rd_idx;
  logic              rd_valid;
  logic [TAG_W-1:0]  rd_tag;
  logic [ADDR_W-1:0] rd_last;
  logic [ADDR_W-1:0] rd_stride;
  logic [CONF_W-1:0] rd_conf;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [TAG_W-1:0]  wr_tag;
  logic [ADDR_W-1:0] wr_last;
  logic [ADDR_W-1:0] wr_stride;
  logic [CONF_W-1:0] wr_conf;
  pf_reason_e        cand_reason;
  logic              cand_fire;
  logic [ADDR_W-1:0] cand_addr;
  logic [ADDR_W-1:0] cand_line;
  logic [ADDR_W-1:0] cand_stride;
  logic              last_valid;
  logic [ADDR_W-1:0] last_line;

  spf_table #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W),
    .ADDR_W(ADDR_W), .CONF_W(CONF_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_tag(rd_tag),
    .rd_last(rd_last), .rd_stride(rd_stride), .rd_conf(rd_conf),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .wr_last(wr_last), .wr_stride(wr_stride), .wr_conf(wr_conf)
  );

  spf_predict #(
    .ADDR_W(ADDR_W), .PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W),
    .CONF_W(CONF_W), .CONF_FIRE(CONF_FIRE), .LINE_LSB(LINE_LSB),
    .PAGE_LSB(PAGE_LSB), .MAX_STRIDE(MAX_STRIDE)
  ) u_predict (
    .ld_valid(ld_valid), .ld_pc(ld_pc), .ld_addr(ld_addr),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_tag(rd_tag),
    .rd_last(rd_last), .rd_stride(rd_stride), .rd_conf(rd_conf),
    .last_valid(last_valid), .last_line(last_line),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .wr_last(wr_last), .wr_stride(wr_stride), .wr_conf(wr_conf),
    .cand_reason(cand_reason), .cand_fire(cand_fire),
    .cand_addr(cand_addr), .cand_line(cand_line), .cand_stride(cand_stride)
  );

  spf_issue #(
    .ADDR_W(ADDR_W)
  ) u_issue (
    .clk(clk), .rst_n(rst_n),
    .cand_fire(cand_fire), .cand_line(cand_line), .pf_ready(pf_ready),
    .pf_valid(pf_valid), .pf_addr(pf_addr),
    .last_valid(last_valid), .last_line(last_line)
  );

endmodule

// File: rtl/spf_checker.sv
module spf_checker
  import stride_pf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_LSB   = 6,
  parameter int PAGE_LSB   = 12,
  parameter int MAX_STRIDE = 2048
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_valid,
  input logic [ADDR_W-1:0] ld_addr,
  input logic              pf_ready,
  input logic              pf_valid,
  input logic [ADDR_W-1:0] pf_addr,
  input pf_reason_e        cand_reason,
  input logic [ADDR_W-1:0] cand_addr,
  input logic [ADDR_W-1:0] cand_line,
  input logic [ADDR_W-1:0] cand_stride
);

  localparam logic [ADDR_W-1:0] LOW_LINE  = (ADDR_W'(1) << LINE_LSB) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ~((ADDR_W'(1) << PAGE_LSB) - ADDR_W'(1));

  logic              fire;
  logic [ADDR_W-1:0] mag;

  assign fire = (cand_reason == PFR_FIRE);
  assign mag  = cand_stride[ADDR_W-1] ? (ADDR_W'(0) - cand_stride) : cand_stride;

  AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> ((pf_addr & LOW_LINE) == '0)); // R4

  AST_SLOT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (pf_valid && (pf_addr == $past(cand_line)))); // R4

  AST_TARGET_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (cand_addr == ld_addr + cand_stride)); // R4

  AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> pf_valid); // R11

  AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && pf_ready && !fire) |=> !pf_valid); // R11

  AST_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_valid) |-> $past(ld_valid)); // R3

  AST_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (((cand_addr ^ ld_addr) & PAGE_MASK) == '0)); // R8

  AST_STRIDE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (mag <= ADDR_W'(MAX_STRIDE))); // R6

  AST_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (cand_stride != '0)); // R7

endmodule

bind stride_pf spf_checker #(
  .ADDR_W(ADDR_W), .LINE_LSB(LINE_LSB), .PAGE_LSB(PAGE_LSB), .MAX_STRIDE(MAX_STRIDE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
  .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr),
  .cand_reason(cand_reason), .cand_addr(cand_addr),
  .cand_line(cand_line), .cand_stride(cand_stride)
);

// File: tb/stride_pf_tb.sv
`timescale 1ns/1ps
module stride_pf_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_valid;
  logic [11:0] ld_pc;
  logic [31:0] ld_addr;
  logic        pf_ready;
  logic        pf_valid;
  logic [31:0] pf_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  stride_pf u_dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_pc(ld_pc),
    .ld_addr(ld_addr), .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr)
  );

  // Behavioural reference: per-slot history in associative arrays
  int          m_tag  [int];
  bit [31:0]   m_last [int];
  bit [31:0]   m_str  [int];
  int          m_conf [int];
  bit          mv;
  bit [31:0]   ma;
  bit          mlv;
  bit [31:0]   ml;

  task automatic check(string req, bit [31:0] act, bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_tag.delete(); m_last.delete(); m_str.delete(); m_conf.delete();
    mv = 0; ma = 0; mlv = 0; ml = 0;
  endtask

  task automatic model_step(bit v, bit [11:0] pc, bit [31:0] a, bit rdy);
    bit        fire;
    int        k;
    int        tg;
    bit [31:0] d;
    bit [31:0] p;
    bit [31:0] line;
    bit        match;
    longint    sd;
    longint    mg;
    fire = 0;
    line = 0;
    if (v) begin
      k  = int'(pc) % 16;
      tg = int'(pc) / 16;
      if (m_tag.exists(k) && m_tag[k] == tg) begin
        d     = a - m_last[k];
        match = (d == m_str[k]);
        if (match) m_conf[k] = (m_conf[k] == 3) ? 3 : m_conf[k] + 1;
        else begin m_conf[k] = 0; m_str[k] = d; end
        m_last[k] = a;
        sd   = longint'($signed(d));
        mg   = (sd < 0) ? -sd : sd;
        p    = a + d;
        line = {p[31:6], 6'b0};
        if (match && m_conf[k] >= 2 && sd != 0 && mg <= 2048 &&
            p[31:12] == a[31:12] && !(mlv && line == ml))
          fire = 1;
      end else begin
        m_tag[k] = tg; m_last[k] = a; m_str[k] = 0; m_conf[k] = 0;
      end
    end
    if (fire) begin mv = 1; ma = line; ml = line; mlv = 1; end
    else if (mv && rdy) mv = 0;
  endtask

  // Drive on a falling edge, compare on the next falling edge
  task automatic step(string req, bit v, bit [11:0] pc, bit [31:0] a, bit rdy);
    ld_valid = v; ld_pc = pc; ld_addr = a; pf_ready = rdy;
    model_step(v, pc, a, rdy);
    @(posedge clk);
    @(negedge clk);
    check({req, " pf_valid vs model"}, 32'(pf_valid), 32'(mv));
    if (mv) check({req, " pf_addr vs model"}, pf_addr, ma);
    ld_valid = 0;
  endtask

  task automatic ld(string req, bit [11:0] pc, bit [31:0] a);
    step(req, 1'b1, pc, a, 1'b1);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; ld_valid = 0; ld_pc = 0; ld_addr = 0; pf_ready = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 pf_valid after reset", 32'(pf_valid), 0);

    // R3 R4 R8: ascending stride 0x100 walking to a page edge
    for (int i = 0; i < 16; i++) begin
      ld("R4", 12'h040, 32'h1000 + 32'(i) * 32'h100);
      if (i < 3)  check("R3 untrained no request", 32'(pf_valid), 0);
      if (i == 3) check("R4 first target", pf_addr, 32'h1400);
      if (i == 14) check("R4 last in-page target", pf_addr, 32'h1F00);
      if (i == 15) check("R8 page crossing dropped", 32'(pf_valid), 0);
    end

    // R5: descending stride
    for (int i = 0; i < 4; i++) ld("R5", 12'h044, 32'h5800 - 32'(i) * 32'h100);
    check("R5 backward valid", 32'(pf_valid), 1);
    check("R5 backward target", pf_addr, 32'h5400);

    // R6: 2052-byte stride never fires even with target in page
    for (int i = 0; i < 4; i++) ld("R6", 12'h048, 32'h3E804 + 32'(i) * 32'h804);
    check("R6 over cap dropped", 32'(pf_valid), 0);
    // R6: exactly 2048 fires
    for (int i = 0; i < 4; i++) ld("R6", 12'h04C, 32'h4E800 + 32'(i) * 32'h800);
    check("R6 at cap target", pf_addr, 32'h50800);
    check("R6 at cap valid", 32'(pf_valid), 1);

    // R7: zero stride
    for (int i = 0; i < 5; i++) begin
      ld("R7", 12'h050, 32'h6000);
      if (i > 0) check("R7 zero stride no request", 32'(pf_valid), 0);
    end

    // R9: sub-line stride, repeat line dropped after an accepted request
    for (int i = 0; i < 8; i++) begin
      ld("R9", 12'h054, 32'h7000 + 32'(i) * 32'h10);
      if (i == 3) check("R9 first line", pf_addr, 32'h7040);
      if (i == 4) check("R9 same line dropped", 32'(pf_valid), 0);
      if (i == 7) check("R9 next line", pf_addr, 32'h7080);
    end

    // R2: two instructions interleaved
    for (int i = 0; i < 4; i++) begin
      ld("R2", 12'h060, 32'h9000 + 32'(i) * 32'h40);
      if (i == 3) check("R2 first instruction target", pf_addr, 32'h9100);
      ld("R2", 12'h064, 32'hA800 - 32'(i) * 32'h80);
      if (i == 3) check("R2 second instruction target", pf_addr, 32'hA600);
    end

    // R10: aliasing instruction evicts the entry
    for (int i = 0; i < 3; i++) ld("R10", 12'h070, 32'hB000 + 32'(i) * 32'h40);
    ld("R10", 12'h170, 32'h20000);
    ld("R10", 12'h070, 32'hB0C0);
    check("R10 evicted entry retrains", 32'(pf_valid), 0);

    // R3: stride break clears confidence
    for (int i = 0; i < 4; i++) ld("R3", 12'h090, 32'hD000 + 32'(i) * 32'h40);
    check("R3 trained target", pf_addr, 32'hD100);
    ld("R3", 12'h090, 32'hD1C0);
    ld("R3", 12'h090, 32'hD200);
    check("R3 after break no request", 32'(pf_valid), 0);
    ld("R3", 12'h090, 32'hD240);
    check("R3 one match no request", 32'(pf_valid), 0);
    ld("R3", 12'h090, 32'hD280);
    check("R3 retrained target", pf_addr, 32'hD2C0);

    // R11: back-pressure, replacement and drain
    for (int i = 0; i < 4; i++) step("R11", 1'b1, 12'h080, 32'hC000 + 32'(i) * 32'h40, 1'b0);
    check("R11 pending target", pf_addr, 32'hC100);
    step("R11", 1'b0, 12'h000, 32'h0, 1'b0);
    check("R11 held while not ready", 32'(pf_valid), 1);
    step("R11", 1'b1, 12'h080, 32'hC100, 1'b0);
    check("R11 newer replaces pending", pf_addr, 32'hC140);
    step("R11", 1'b0, 12'h000, 32'h0, 1'b0);
    check("R11 still held", 32'(pf_valid), 1);
    step("R11", 1'b0, 12'h000, 32'h0, 1'b1);
    check("R11 drained after handshake", 32'(pf_valid), 0);

    done = 1;
    summary();
    $finish;
  end

endmodule